// File: doc/BRIEF.md
# Interrupt Hold-off Timer

This block delays an interrupt request to the processor for a programmable number of microseconds, so that a burst of events reaches software as one interrupt instead of many. Software programs a 14-bit hold-off value in a delay register and then writes the control register with the master enable set. Each such write opens a fresh hold-off window. While the window runs the interrupt output is masked. Once the window closes, any pending event drives the output high.

Event inputs set a sticky pending bit, which software clears by writing 1 to it. A prescaler turns the core clock into a microsecond tick. It is built from a cycles-per-microsecond parameter and is resynchronised at every window start, so a window lasts exactly delay × cycles-per-microsecond clock cycles. The permitted timing tolerance is therefore met with no error at all.

The delay register reads back with a fixed capability flag in its top bit. The interrupt output is a level, not a pulse. All pins are plain control and status pins: there is no data stream and so no valid/ready handshake.

Top module: `intr_holdoff_top`

## Requirements
- R1: After reset the interrupt output is 0, enable is 0, pending is 0, the timer is idle (`hold_busy`=0) and `rd_delay` reads 16'h8000.
- R2: `rd_delay[13:0]` returns the last value written to `wr_data[13:0]`. `rd_delay[14]` always reads 0. `rd_delay[15]` always reads 1 (coalescing supported), whatever is written.
- R3: A control write with enable=1 and a nonzero held delay D makes `hold_busy` high for exactly D×CYC_PER_US cycles after the write edge. The interrupt output stays 0 during this time, even with events pending.
- R4: A control write with enable=1 while the timer is running restarts the window, which then lasts D×CYC_PER_US cycles from the new write.
- R5: A delay write during a running window leaves that window's length unchanged. The new value takes effect at the next enable=1 write. A delay write in the same cycle as an enable=1 write is not used by that window.
- R6: When the window closes with pending=1 and enable=1, the interrupt output rises in the first cycle in which `hold_busy` is 0.
- R7: With enable=1 and the timer idle, an event drives the interrupt output high in the cycle after the event is sampled.
- R8: With a held delay of 0, an enable=1 write starts no window. The interrupt output rises in the cycle after the write if an event is pending.
- R9: A control write with enable=0 stops the timer and holds the interrupt output low from the next cycle on.
- R10: Writing 1 to the pending-clear field clears pending unless an event arrives in the same cycle, in which case pending stays 1. The timer never changes the pending or enable bits.
- R11: At all times the interrupt output equals enable AND pending AND NOT `hold_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_delay | input | 1 | Write strobe for the delay register |
| wr_data | input | 16 | Delay write data; bits 13:0 are the delay in microseconds |
| wr_ctrl | input | 1 | Write strobe for the control register |
| ctrl_enable | input | 1 | Master enable value written by `wr_ctrl` |
| ctrl_pend_clr | input | 1 | Write 1 with `wr_ctrl` to clear the pending bit |
| evt_in | input | N_EVT | Event sources; any high bit sets pending |
| rd_delay | output | 16 | Delay register read value with capability flag in bit 15 |
| rd_enable | output | 1 | Master enable bit |
| rd_pending | output | 1 | Pending-interrupt bit |
| hold_busy | output | 1 | High while a hold-off window is running |
| irq_out | output | 1 | Level interrupt request to the processor |

## Verification
The assertions assume that the two write strobes and the event inputs are synchronous to `clk` and stable around each edge. They also assume that software never raises `wr_ctrl` with enable=0 and enable=1 at once, which the single `ctrl_enable` pin rules out. The bench drives every input at the falling edge from seeded random draws. Delays are drawn small enough that windows both close and get restarted often, and the draws cover the interleavings of writes and events that the restart and same-cycle rules depend on.

// File: rtl/intr_holdoff_pkg.sv
package intr_holdoff_pkg;
  typedef enum logic {TMR_IDLE = 1'b0, TMR_HOLD = 1'b1} tmr_state_e;
  localparam int REG_W = 16;
endpackage

// File: rtl/holdoff_regs.sv
module holdoff_regs #(
  parameter int DELAY_W = 14,
  parameter int N_EVT   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_delay,
  input  logic [DELAY_W-1:0] wr_delay_val,
  input  logic               wr_ctrl,
  input  logic               ctrl_enable,
  input  logic               ctrl_pend_clr,
  input  logic [N_EVT-1:0]   evt_in,
  output logic [DELAY_W-1:0] delay_q,
  output logic               enable_q,
  output logic               pending_q
);
  logic any_evt;
  assign any_evt = |evt_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delay_q   <= '0;
      enable_q  <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      if (wr_delay) delay_q <= wr_delay_val;
      if (wr_ctrl)  enable_q <= ctrl_enable;
      if (any_evt)
        pending_q <= 1'b1;
      else if (wr_ctrl && ctrl_pend_clr)
        pending_q <= 1'b0;
    end
  end

  // R10: an event in the same cycle as a clear wins
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> pending_q);
  // R10: only a clear write may drop pending
  a_r10_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !(wr_ctrl && ctrl_pend_clr)) |=> pending_q);
  // R10: enable changes only by a control write
  a_r10_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(enable_q));
endmodule

// File: rtl/us_prescaler.sv
module us_prescaler #(
  parameter int CYC_PER_US = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYC_PER_US - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pcnt <= '0;
    else if (restart)      pcnt <= '0;
    else if (pcnt == LAST) pcnt <= '0;
    else                   pcnt <= pcnt + 1'b1;
  end

  assign tick = (pcnt == LAST) && !restart;

  // R3: the count is back at zero right after a restart
  a_r3_presc_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pcnt == '0));
endmodule

// File: rtl/holdoff_timer.sv
module holdoff_timer
  import intr_holdoff_pkg::*;
#(
  parameter int DELAY_W = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               stop,
  input  logic [DELAY_W-1:0] load_val,
  input  logic               tick,
  output logic               busy
);
  tmr_state_e         state;
  logic [DELAY_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TMR_IDLE;
      cnt   <= '0;
    end else if (stop) begin
      state <= TMR_IDLE;
      cnt   <= '0;
    end else if (start) begin
      cnt   <= load_val;
      state <= (load_val == '0) ? TMR_IDLE : TMR_HOLD;
    end else if (state == TMR_HOLD && tick) begin
      if (cnt == DELAY_W'(1)) begin
        state <= TMR_IDLE;
        cnt   <= '0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign busy = (state == TMR_HOLD);

  // R3: a nonzero start opens a window
  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop && load_val != '0) |=> busy);
  // R8: a zero start opens none
  a_r8_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (start && load_val == '0) |=> !busy);
  // R9: stop ends the window
  a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !busy);
  // R5: the running count moves only on a tick or a new start
  a_r5_cnt_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && !stop && !tick) |=> $stable(cnt));
endmodule

// File: rtl/intr_holdoff_top.sv
module intr_holdoff_top
  import intr_holdoff_pkg::*;
#(
  parameter int DELAY_W    = 14,
  parameter int N_EVT      = 4,
  parameter int CYC_PER_US = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_delay,
  input  logic [15:0]      wr_data,
  input  logic             wr_ctrl,
  input  logic             ctrl_enable,
  input  logic             ctrl_pend_clr,
  input  logic [N_EVT-1:0] evt_in,
  output logic [15:0]      rd_delay,
  output logic             rd_enable,
  output logic             rd_pending,
  output logic             hold_busy,
  output logic             irq_out
);
  localparam int PAD_W = REG_W - 1 - DELAY_W;

  logic [DELAY_W-1:0] delay_q;
  logic enable_q, pending_q, start, stop, tick, busy;

  assign start = wr_ctrl && ctrl_enable;
  assign stop  = wr_ctrl && !ctrl_enable;

  holdoff_regs #(.DELAY_W(DELAY_W), .N_EVT(N_EVT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_delay(wr_delay),
    .wr_delay_val(wr_data[DELAY_W-1:0]), .wr_ctrl(wr_ctrl),
    .ctrl_enable(ctrl_enable), .ctrl_pend_clr(ctrl_pend_clr),
    .evt_in(evt_in), .delay_q(delay_q), .enable_q(enable_q),
    .pending_q(pending_q)
  );

  us_prescaler #(.CYC_PER_US(CYC_PER_US)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(start), .tick(tick)
  );

  holdoff_timer #(.DELAY_W(DELAY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .load_val(delay_q), .tick(tick), .busy(busy)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_delay = {1'b1, {PAD_W{1'b0}}, delay_q};
    end else begin : g_nopad
      assign rd_delay = {1'b1, delay_q};
    end
  endgenerate

  assign rd_enable  = enable_q;
  assign rd_pending = pending_q;
  assign hold_busy  = busy;
  assign irq_out    = enable_q && pending_q && !busy;

  // R9: disable write silences the output next cycle
  a_r9_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !irq_out);
  // R7: event on an idle, enabled block raises the output next cycle
  a_r7_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q && !busy && (|evt_in) && !wr_ctrl) |=> irq_out);
  // R6: a window closing with work pending raises the output
  a_r6_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_ctrl && enable_q && pending_q) ##1 !busy |-> irq_out);
endmodule

// File: tb/intr_holdoff_top_bench.sv
`timescale 1ns/1ps
module intr_holdoff_top_bench;
  localparam int C = 4;
  localparam int NE = 4;

  logic clk = 0, rst_n = 0;
  logic wr_delay = 0, wr_ctrl = 0, ctrl_enable = 0, ctrl_pend_clr = 0;
  logic [15:0] wr_data = '0;
  logic [NE-1:0] evt_in = '0;
  logic [15:0] rd_delay;
  logic rd_enable, rd_pending, hold_busy, irq_out;

  intr_holdoff_top #(.DELAY_W(14), .N_EVT(NE), .CYC_PER_US(C)) u_intr_holdoff_top (
    .clk(clk), .rst_n(rst_n), .wr_delay(wr_delay), .wr_data(wr_data),
    .wr_ctrl(wr_ctrl), .ctrl_enable(ctrl_enable), .ctrl_pend_clr(ctrl_pend_clr),
    .evt_in(evt_in), .rd_delay(rd_delay), .rd_enable(rd_enable),
    .rd_pending(rd_pending), .hold_busy(hold_busy), .irq_out(irq_out)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  int m_delay = 0, m_rem = 0;
  bit m_en = 0, m_pend = 0;

  function automatic bit exp_irq();
    return m_en && m_pend && (m_rem == 0);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, rd_delay, {2'b10, 14'(m_delay)}, "rd_delay");
    chk(tag, 16'(rd_enable), 16'(m_en), "enable");
    chk(tag, 16'(rd_pending), 16'(m_pend), "pending");
    chk(tag, 16'(hold_busy), 16'(m_rem != 0), "busy");
    chk(tag, 16'(irq_out), 16'(exp_irq()), "irq");
  endtask

  // one cycle: drive at negedge, model update at posedge, compare next negedge
  task automatic step(string tag, bit wd, logic [15:0] wdat, bit wc, bit en,
                      bit clr, logic [NE-1:0] ev);
    wr_delay = wd; wr_data = wdat; wr_ctrl = wc; ctrl_enable = en;
    ctrl_pend_clr = clr; evt_in = ev;
    @(posedge clk);
    if (wc && en)      m_rem = m_delay * C;
    else if (wc && !en) m_rem = 0;
    else if (m_rem > 0) m_rem--;
    if (wd) m_delay = int'(wdat[13:0]);
    if (wc) m_en = en;
    if (|ev) m_pend = 1;
    else if (wc && clr) m_pend = 0;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, '0, 0, 0, 0, '0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1;
    @(negedge clk);
    check_all("R1");

    // R2: writes to bits 15:14 do not stick; flag reads 1
    step("R2", 1, 16'hFFFF, 0, 0, 0, '0);
    step("R2", 1, 16'h4005, 0, 0, 0, '0);

    // R3 / R6: window of 5us, event inside, irq at close
    step("R3", 0, '0, 1, 1, 0, '0);
    step("R3", 0, '0, 0, 0, 0, 4'b0010);
    idle("R3", 5 * C - 3);
    idle("R6", 4);

    // R7: clear, then event after expiry
    step("R10", 0, '0, 1, 1, 1, '0);
    idle("R7", 5 * C + 1);
    step("R7", 0, '0, 0, 0, 0, 4'b1000);
    idle("R7", 2);

    // R4: restart mid-window
    step("R4", 0, '0, 1, 1, 0, '0);
    idle("R4", 2 * C + 1);
    step("R4", 0, '0, 1, 1, 0, '0);
    idle("R4", 5 * C + 2);

    // R5: delay write in same cycle as start, and mid-window
    step("R5", 1, 16'd2, 1, 1, 0, '0);
    idle("R5", 3);
    step("R5", 1, 16'd9, 0, 0, 0, '0);
    idle("R5", 5 * C);
    step("R5", 0, '0, 1, 1, 0, '0);
    idle("R5", 9 * C + 2);

    // R10: clear with event same cycle keeps pending; clear alone drops it
    step("R10", 0, '0, 1, 1, 1, 4'b0001);
    step("R10", 0, '0, 1, 1, 1, '0);
    idle("R10", 9 * C + 2);

    // R8: zero delay
    step("R8", 1, 16'd0, 0, 0, 0, 4'b0100);
    step("R8", 0, '0, 1, 1, 0, '0);
    idle("R8", 2);

    // R9: stop mid window
    step("R9", 1, 16'd6, 0, 0, 0, '0);
    step("R9", 0, '0, 1, 1, 0, '0);
    idle("R9", 5);
    step("R9", 0, '0, 1, 0, 0, '0);
    idle("R9", 3);

    // R11: random mix
    for (int k = 0; k < 4000; k++) begin
      bit wd, wc, en, clr;
      logic [15:0] d;
      logic [NE-1:0] ev;
      wd  = ($urandom % 20) == 0;
      d   = 16'($urandom % 8) | (16'($urandom % 4) << 14);
      wc  = ($urandom % 25) == 0;
      en  = ($urandom % 5) != 0;
      clr = ($urandom % 2) == 0;
      ev  = (($urandom % 12) == 0) ? NE'($urandom) : '0;
      step("R11", wd, d, wc, en, clr, ev);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule